// File: doc/BRIEF.md
# Byte-wide arithmetic logic unit

This block is the combinational datapath core of a small teaching processor whose registers are one byte wide. The processor's control unit presents the four-bit opcode field of the current instruction together with two register values and a four-bit rotate count taken from the instruction. The unit returns one byte in the same cycle. It supports wrapping two's-complement addition, the three bitwise operations OR, AND and XOR, and rotation to the right by a variable amount.

An equality output also compares the two operand bytes on every cycle. The control unit routes the register named by a conditional jump to one operand and the reference register to the other, and reads the flag to decide whether to take the jump. Opcodes that this unit does not execute give a zero result and raise an invalid-operation output, so the control unit can tell them apart from a genuine zero. The block holds no state.

Top module: `alu8_core`

## Requirements
- R1: With `op_code` = 4'h5, `result` is (`opnd_a` + `opnd_b`) modulo 256; carry and overflow are not reported.
- R2: With `op_code` = 4'h7, `result` is the bitwise OR of `opnd_a` and `opnd_b` (9D OR 17 gives 9F).
- R3: With `op_code` = 4'h8, `result` is the bitwise AND of `opnd_a` and `opnd_b`.
- R4: With `op_code` = 4'h9, `result` is the bitwise XOR of `opnd_a` and `opnd_b`.
- R5: With `op_code` = 4'hA, `result` is `opnd_a` rotated right by `rot_cnt` bit positions, bit 0 moving into bit 7 on each step (9D gives CE after one step and 67 after two); a count of 0 returns `opnd_a` unchanged.
- R6: A rotate count of 8 or more is taken modulo 8: only `rot_cnt[2:0]` selects the amount, and `rot_cnt[3]` has no effect.
- R7: For any `op_code` other than 4'h5, 4'h7, 4'h8, 4'h9 and 4'hA, `result` is 8'h00 and `bad_op` is 1; for those five codes `bad_op` is 0.
- R8: `eq_hit` is 1 exactly when `opnd_a` and `opnd_b` are bit-identical, whatever the opcode.
- R9: A rotation ignores `opnd_b`, and addition and the bitwise operations ignore `rot_cnt`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code | input | 4 | Operation selector, the instruction's opcode value |
| opnd_a | input | 8 | First operand; the value rotated by opcode A |
| opnd_b | input | 8 | Second operand; the reference value for the equality flag |
| rot_cnt | input | 4 | Rotate-right amount, used modulo 8 |
| result | output | 8 | Operation result, or zero for an unsupported opcode |
| bad_op | output | 1 | High when `op_code` is not one of the executed operations |
| eq_hit | output | 1 | High when `opnd_a` equals `opnd_b` |

## Verification
Every output of this block is due zero clock cycles after its inputs change. The result, the invalid flag and the equality flag all settle within the cycle that presents the operands, and none waits for a later edge. The bench applies each operand set just after a rising edge of its reference clock and samples all three outputs at the following falling edge. This leaves half a period for the data to settle and keeps sampling away from the edge where the inputs move. Each directed test that shows an input is ignored changes only that input between two such samples and compares the output with the value computed beforehand.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    // Opcode values of the executed operations
    typedef enum logic [3:0] {
        OP_ADD = 4'h5,
        OP_OR  = 4'h7,
        OP_AND = 4'h8,
        OP_XOR = 4'h9,
        OP_ROR = 4'hA
    } alu_op_e;

    // Bitwise sub-function
    typedef enum logic [1:0] {
        LG_OR  = 2'd0,
        LG_AND = 2'd1,
        LG_XOR = 2'd2
    } logic_fn_e;

    // Which functional unit drives the result
    typedef struct packed {
        logic      use_add;
        logic      use_logic;
        logic      use_rot;
        logic      invalid;
        logic_fn_e lfn;
    } unit_sel_t;

    function automatic unit_sel_t decode_op(input logic [3:0] op);
        unit_sel_t s;
        s = '{use_add: 1'b0, use_logic: 1'b0, use_rot: 1'b0,
              invalid: 1'b0, lfn: LG_OR};
        case (op)
            OP_ADD: s.use_add = 1'b1;
            OP_OR:  begin s.use_logic = 1'b1; s.lfn = LG_OR;  end
            OP_AND: begin s.use_logic = 1'b1; s.lfn = LG_AND; end
            OP_XOR: begin s.use_logic = 1'b1; s.lfn = LG_XOR; end
            OP_ROR: s.use_rot = 1'b1;
            default: s.invalid = 1'b1;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/alu8_decode.sv
module alu8_decode
    import alu8_pkg::*;
(
    input  logic [3:0] op_code,
    output unit_sel_t  sel
);

    assign sel = decode_op(op_code);

    always_comb begin
        if (!$isunknown(op_code)) begin
            AST_SEL_ONEHOT: assert ($onehot0({sel.use_add, sel.use_logic, sel.use_rot}) &&
                                    (sel.invalid == ({sel.use_add, sel.use_logic, sel.use_rot} == 3'b000))); // R7
        end
    end

endmodule

// File: rtl/alu8_adder.sv
module alu8_adder #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] sum
);

    logic [DATA_W:0] carry;
    logic            unused_carry;

    assign carry[0] = 1'b0;

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign sum[i]     = a[i] ^ b[i] ^ carry[i];
        assign carry[i+1] = (a[i] & b[i]) | (carry[i] & (a[i] ^ b[i]));
    end

    // carry out is dropped: the sum wraps
    assign unused_carry = carry[DATA_W];

    always_comb begin
        if (!$isunknown({a, b})) begin
            AST_ADD_WRAP: assert (DATA_W'(sum - b) == a); // R1
        end
    end

endmodule

// File: rtl/alu8_bitwise.sv
module alu8_bitwise
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic_fn_e         fn,
    output logic [DATA_W-1:0] y
);

    always_comb begin
        case (fn)
            LG_OR:   y = a | b;
            LG_AND:  y = a & b;
            LG_XOR:  y = a ^ b;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/alu8_rotr.sv
module alu8_rotr #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 4
) (
    input  logic [DATA_W-1:0] x,
    input  logic [CNT_W-1:0]  cnt,
    output logic [DATA_W-1:0] y
);

    localparam int SHW = $clog2(DATA_W);

    logic [SHW:0][DATA_W-1:0] stg;
    logic                     unused_hi;

    assign stg[0] = x;

    // log-depth barrel: stage k rotates by 2**k when count bit k is set
    for (genvar k = 0; k < SHW; k++) begin : g_stage
        localparam int D = 1 << k;
        assign stg[k+1] = cnt[k] ? {stg[k][D-1:0], stg[k][DATA_W-1:D]} : stg[k];
    end

    assign y = stg[SHW];

    // upper count bits are the modulo part of the amount
    assign unused_hi = ^cnt[CNT_W-1:SHW];

    always_comb begin
        if (!$isunknown({x, cnt})) begin
            AST_ROT_POPCOUNT: assert ($countones(y) == $countones(x)); // R5
            AST_ROT_ZERO_ID: assert ((cnt[SHW-1:0] != '0) || (y == x)); // R6
        end
    end

endmodule

// File: rtl/alu8_eq.sv
module alu8_eq #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic              eq
);

    assign eq = ~|(a ^ b);

endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 4
) (
    input  logic [3:0]        op_code,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [CNT_W-1:0]  rot_cnt,
    output logic [DATA_W-1:0] result,
    output logic              bad_op,
    output logic              eq_hit
);

    unit_sel_t         sel;
    logic [DATA_W-1:0] add_y;
    logic [DATA_W-1:0] lg_y;
    logic [DATA_W-1:0] rot_y;

    alu8_decode u_dec (
        .op_code (op_code),
        .sel     (sel)
    );

    alu8_adder #(.DATA_W(DATA_W)) u_add (
        .a   (opnd_a),
        .b   (opnd_b),
        .sum (add_y)
    );

    alu8_bitwise #(.DATA_W(DATA_W)) u_lg (
        .a  (opnd_a),
        .b  (opnd_b),
        .fn (sel.lfn),
        .y  (lg_y)
    );

    alu8_rotr #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_rot (
        .x   (opnd_a),
        .cnt (rot_cnt),
        .y   (rot_y)
    );

    alu8_eq #(.DATA_W(DATA_W)) u_eq (
        .a  (opnd_a),
        .b  (opnd_b),
        .eq (eq_hit)
    );

    // AND-OR result mux: selects are one-hot or all clear
    assign result = ({DATA_W{sel.use_add}}   & add_y) |
                    ({DATA_W{sel.use_logic}} & lg_y)  |
                    ({DATA_W{sel.use_rot}}   & rot_y);
    assign bad_op = sel.invalid;

    always_comb begin
        if (!$isunknown({op_code, opnd_a, opnd_b, rot_cnt})) begin
            AST_BAD_ZERO: assert (!bad_op || (result == '0)); // R7
            AST_EQ_XOR_ZERO: assert (!(eq_hit && (op_code == OP_XOR)) || (result == '0)); // R8
        end
    end

endmodule

// File: tb/alu8_core_test.sv
module alu8_core_test;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 18;

    // {op[33:30], a[29:22], b[21:14], cnt[13:10], exp[9:2], bad[1], eq[0]}
    localparam logic [33:0] VEC [NVEC] = '{
        {4'h5, 8'h17, 8'h2A, 4'h0, 8'h41, 1'b0, 1'b0},
        {4'h5, 8'hFF, 8'h01, 4'h0, 8'h00, 1'b0, 1'b0},
        {4'h5, 8'h80, 8'h80, 4'h0, 8'h00, 1'b0, 1'b1},
        {4'h7, 8'h9D, 8'h17, 4'h0, 8'h9F, 1'b0, 1'b0},
        {4'h8, 8'h9D, 8'h17, 4'h0, 8'h15, 1'b0, 1'b0},
        {4'h9, 8'h9D, 8'h17, 4'h0, 8'h8A, 1'b0, 1'b0},
        {4'h9, 8'h5A, 8'h5A, 4'h0, 8'h00, 1'b0, 1'b1},
        {4'hA, 8'h9D, 8'h00, 4'h1, 8'hCE, 1'b0, 1'b0},
        {4'hA, 8'h9D, 8'h00, 4'h2, 8'h67, 1'b0, 1'b0},
        {4'hA, 8'h9D, 8'h00, 4'h0, 8'h9D, 1'b0, 1'b0},
        {4'hA, 8'h9D, 8'h00, 4'h9, 8'hCE, 1'b0, 1'b0},
        {4'hA, 8'h9D, 8'h00, 4'h8, 8'h9D, 1'b0, 1'b0},
        {4'hA, 8'h81, 8'h00, 4'h7, 8'h03, 1'b0, 1'b0},
        {4'hC, 8'h12, 8'h12, 4'h0, 8'h00, 1'b1, 1'b1},
        {4'h0, 8'h33, 8'h44, 4'h0, 8'h00, 1'b1, 1'b0},
        {4'hF, 8'hFF, 8'h00, 4'h3, 8'h00, 1'b1, 1'b0},
        {4'h5, 8'h01, 8'h02, 4'hF, 8'h03, 1'b0, 1'b0},
        {4'hA, 8'h01, 8'hFF, 4'h1, 8'h80, 1'b0, 1'b0}
    };

    logic       clk = 1'b0;
    logic [3:0] op_code = 4'h0;
    logic [7:0] opnd_a = 8'h00;
    logic [7:0] opnd_b = 8'h00;
    logic [3:0] rot_cnt = 4'h0;
    logic [7:0] result;
    logic       bad_op;
    logic       eq_hit;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu8_core uut (
        .op_code (op_code),
        .opnd_a  (opnd_a),
        .opnd_b  (opnd_b),
        .rot_cnt (rot_cnt),
        .result  (result),
        .bad_op  (bad_op),
        .eq_hit  (eq_hit)
    );

    function automatic string req_of(input logic [3:0] op, input logic [3:0] c);
        case (op)
            4'h5: return "R1";
            4'h7: return "R2";
            4'h8: return "R3";
            4'h9: return "R4";
            4'hA: return c[3] ? "R6" : "R5";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %02h expected %02h (op %h a %02h b %02h cnt %h)",
                     req, act, exp, op_code, opnd_a, opnd_b, rot_cnt);
        end
    endtask

    task automatic apply(input logic [3:0] op, input logic [7:0] a,
                         input logic [7:0] b, input logic [3:0] c);
        @(posedge clk);
        op_code = op;
        opnd_a  = a;
        opnd_b  = b;
        rot_cnt = c;
        @(negedge clk);
    endtask

    initial begin
        // idle state: all inputs zero, opcode 0 is unsupported, operands equal
        @(negedge clk);
        check("R7", result, 8'h00);
        check("R7", {7'd0, bad_op}, 8'h01);
        check("R8", {7'd0, eq_hit}, 8'h01);

        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i][33:30], VEC[i][29:22], VEC[i][21:14], VEC[i][13:10]);
            check(req_of(VEC[i][33:30], VEC[i][13:10]), result, VEC[i][9:2]);
            check("R7", {7'd0, bad_op}, {7'd0, VEC[i][1]});
            check("R8", {7'd0, eq_hit}, {7'd0, VEC[i][0]});
        end

        // R9: rotation ignores opnd_b
        for (int b = 0; b < 256; b += 51) begin
            apply(4'hA, 8'h9D, 8'(b), 4'h2);
            check("R9", result, 8'h67);
        end
        // R9: add and bitwise ignore rot_cnt
        for (int c = 0; c < 16; c++) begin
            apply(4'h5, 8'hF0, 8'h21, 4'(c));
            check("R9", result, 8'h11);
            apply(4'h8, 8'hF0, 8'h3C, 4'(c));
            check("R9", result, 8'h30);
        end

        // R6: all 16 counts against a modulo-8 model
        for (int c = 0; c < 16; c++) begin
            logic [15:0] dbl;
            logic [7:0]  exp_r;
            dbl   = {8'hB4, 8'hB4} >> (c % 8);
            exp_r = dbl[7:0];
            apply(4'hA, 8'hB4, 8'h00, 4'(c));
            check("R6", result, exp_r);
        end

        // R7: every unsupported opcode
        for (int op = 0; op < 16; op++) begin
            if (op != 5 && op != 7 && op != 8 && op != 9 && op != 10) begin
                apply(4'(op), 8'hA5, 8'h5A, 4'h1);
                check("R7", result, 8'h00);
                check("R7", {7'd0, bad_op}, 8'h01);
            end
        end

        // R8: equality independent of opcode
        for (int op = 0; op < 16; op++) begin
            apply(4'(op), 8'h3C, 8'h3C, 4'h0);
            check("R8", {7'd0, eq_hit}, 8'h01);
            apply(4'(op), 8'h3C, 8'h3D, 4'h0);
            check("R8", {7'd0, eq_hit}, 8'h00);
        end

        // R1: exhaustive-ish add against modulo model
        for (int a = 0; a < 256; a += 17) begin
            for (int b = 0; b < 256; b += 29) begin
                apply(4'h5, 8'(a), 8'(b), 4'h0);
                check("R1", result, 8'((a + b) % 256));
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule